// File: doc/BRIEF.md
# Backup-Mode Entry and Wakeup Sequencer

This block decides when a small 4-bit processor core may stop its clock and keep its RAM. It also decides when the core may start again. It watches the decoded instruction stream for the power-off opcode. When that opcode retires on two instructions in a row, the block drops the core clock enable, pulses a stack-pointer load strobe and sets a sticky power-down flag.

While in backup, the block watches for a wake condition. One wake pin is edge-sensitive, and its polarity is programmable. Seven port pins are level-sensitive and active-low, and they are enabled in two groups. The detected event passes through a sticky capture and a synchronizer chain before the clock enable is raised again. At that point the core is told to restart at address zero of page zero.

An external reset also restarts the core, and it clears the flag. Software can therefore use a test-and-skip instruction to tell a warm start from a cold start. The block itself runs on an always-on clock. Only `core_clk_en` reaches the core.

Top module: `backup_wake_ctrl`

## Requirements
- R1: `in_backup` rises one cycle after a second valid power-off instruction that directly follows another valid power-off instruction. Cycles with `instr_valid` low do not break the pair. A single power-off instruction does not enter backup. A valid non-power-off instruction between two power-off instructions also prevents entry.
- R2: `core_clk_en` is 0 in every cycle that `in_backup` is 1. It is 1 during reset and in normal running.
- R3: Bit 2 of `wake_ctl` selects the polarity of the edge wake pin: 1 means a rising edge (low to high) and 0 means a falling edge (high to low). An edge in the other direction does not wake the core.
- R4: The edge wake pin wakes the core whatever the values of `wake_ctl` bits 1:0.
- R5: A low level on `lvl_pins[2:0]` wakes the core only when `wake_ctl` bit 0 is 1. A low level on `lvl_pins[6:3]` wakes the core only when `wake_ctl` bit 1 is 1.
- R6: In normal running, an edge of the selected polarity on the edge pin gives a one-cycle `ext_irq_req` pulse one cycle later. An edge that causes a wake from backup never raises `ext_irq_req`.
- R7: Suppose a wake condition is present at clock edge k. Then `in_backup` stays 1 through edge k+2. After edge k+3, `in_backup` is 0, `core_clk_en` is 1 and `restart_req` is 1 for exactly one cycle. `restart_req` is also 1 while reset is held.
- R8: `pdn_flag` is 0 after reset and becomes 1 on entry to backup. It stays 1 through the wake. `skip_req` equals `pdn_flag` whenever a valid test instruction is presented.
- R9: On entry to backup, `sp_load` is 1 for one cycle and `sp_load_val` is 3.
- R10: Reset in the same cycle as a wake event wins. Afterwards the block is running and `pdn_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low external reset (cold start) |
| instr_valid | input | 1 | An instruction is decoded this cycle |
| instr_is_pof | input | 1 | The decoded instruction is the power-off opcode |
| instr_is_test | input | 1 | The decoded instruction tests the power-down flag |
| wake_ctl | input | 3 | Wakeup control: bit0 group A enable, bit1 group B enable, bit2 edge polarity |
| edge_pin | input | 1 | Edge-sensitive wake and interrupt pin |
| lvl_pins | input | 7 | Active-low level wake pins, [2:0] group A, [6:3] group B |
| core_clk_en | output | 1 | Clock enable to the core |
| in_backup | output | 1 | Backup state indicator |
| restart_req | output | 1 | Restart at page 0 address 0 and reinitialize registers |
| sp_load | output | 1 | Load strobe for the stack pointer |
| sp_load_val | output | 2 | Value loaded into the stack pointer |
| pdn_flag | output | 1 | Sticky power-down flag |
| skip_req | output | 1 | Skip the next instruction (flag test result) |
| ext_irq_req | output | 1 | External interrupt request pulse |

## Verification
The hardest situation to reach is a wake on exactly the right source while every other source stays quiet. The edge pin has to rest at the level opposite the selected polarity before the power-off pair is issued. Otherwise the pin's own setup would look like a wake or an interrupt. The bench therefore starts each case from a reset with the pins already at their rest levels. It then sweeps both polarities, all four group-enable settings, the correct edge, the reversed edge and each of the seven level pins. For every case it predicts wake or no wake from the enable bits, and checks the exact edge at which the clock returns. The coincident reset-and-wake case is produced by driving both in the same cycle while in backup.

// File: rtl/bwc_pkg.sv
// Shared types and control-field positions for the backup/wakeup sequencer.
package bwc_pkg;
    typedef enum logic {
        PS_RUN    = 1'b0,
        PS_BACKUP = 1'b1
    } pwr_state_e;

    localparam int CTL_W        = 3;
    localparam int CTL_GRP_A    = 0;
    localparam int CTL_GRP_B    = 1;
    localparam int CTL_EDGE_POL = 2;
endpackage

// File: rtl/bwc_entry_det.sv
// Detects two consecutive valid power-off instructions.
// Assumes: invalid cycles (bubbles) do not break the pair; disarmed while in backup.
module bwc_entry_det (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic instr_valid,
    input  logic instr_is_pof,
    output logic enter
);
    logic prev_pof;

    // Remember whether the last valid instruction was a power-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_pof <= 1'b0;
        end else if (!armed) begin
            prev_pof <= 1'b0;
        end else if (instr_valid) begin
            prev_pof <= instr_is_pof;
        end
    end

    assign enter = armed & instr_valid & instr_is_pof & prev_pof;
endmodule

// File: rtl/bwc_wake_det.sv
// Wake-source detector: one edge pin with programmable polarity (always enabled)
// and grouped active-low level pins. The edge detector is shared with the
// run-mode external interrupt, which is suppressed while in backup.
// Assumes: pins are already synchronous to the always-on clock.
module bwc_wake_det
    import bwc_pkg::*;
#(
    parameter int NUM_GRP_A = 3,
    parameter int NUM_GRP_B = 4,
    localparam int NUM_LVL  = NUM_GRP_A + NUM_GRP_B
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_backup,
    input  logic [CTL_W-1:0]   wake_ctl,
    input  logic               edge_pin,
    input  logic [NUM_LVL-1:0] lvl_pins,
    output logic               wake_evt,
    output logic               ext_irq_req
);
    logic               edge_q;
    logic               edge_hit;
    logic               lvl_hit;
    logic [NUM_LVL-1:0] lvl_en;

    // Previous edge-pin value; tracks the pin during reset to avoid a false edge.
    always_ff @(posedge clk) begin
        edge_q <= edge_pin;
    end

    assign edge_hit = wake_ctl[CTL_EDGE_POL] ? (edge_pin & ~edge_q)
                                             : (~edge_pin & edge_q);

    // Per-pin enable taken from the group bit the pin belongs to.
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl_en
        if (i < NUM_GRP_A) begin : g_a
            assign lvl_en[i] = wake_ctl[CTL_GRP_A];
        end else begin : g_b
            assign lvl_en[i] = wake_ctl[CTL_GRP_B];
        end
    end

    assign lvl_hit  = |(lvl_en & ~lvl_pins);
    assign wake_evt = in_backup & (edge_hit | lvl_hit);

    // Run-mode interrupt request; never raised by a backup wake edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_irq_req <= 1'b0;
        end else begin
            ext_irq_req <= ~in_backup & edge_hit;
        end
    end

    AST_IRQ_QUIET_IN_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        in_backup |=> !ext_irq_req); // R6
endmodule

// File: rtl/bwc_wake_sync.sv
// Captures a wake event stickily and passes it through a synchronizer chain.
// Assumes: all state clears as soon as backup is left.
module bwc_wake_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_backup,
    input  logic wake_evt,
    output logic wake_go
);
    logic                   hit;
    logic [SYNC_STAGES-1:0] chain;

    // Sticky capture of the detected event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit <= 1'b0;
        end else begin
            hit <= in_backup & (hit | wake_evt);
        end
    end

    // Synchronizer chain behind the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= in_backup & hit;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain[i] <= in_backup & chain[i-1];
            end
        end
    end

    assign wake_go = in_backup & chain[SYNC_STAGES-1];
endmodule

// File: rtl/backup_wake_ctrl.sv
// Backup-mode sequencer: enters backup on two consecutive power-off
// instructions, gates the core clock, and restarts the core on a wake or reset.
// Assumes: clk is always on; rst_n is the external cold reset.
module backup_wake_ctrl
    import bwc_pkg::*;
#(
    parameter int NUM_GRP_A   = 3,
    parameter int NUM_GRP_B   = 4,
    parameter int SYNC_STAGES = 2,
    parameter int SP_W        = 2,
    parameter int SP_BACKUP   = 3,
    localparam int NUM_LVL    = NUM_GRP_A + NUM_GRP_B
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic               instr_is_pof,
    input  logic               instr_is_test,
    input  logic [CTL_W-1:0]   wake_ctl,
    input  logic               edge_pin,
    input  logic [NUM_LVL-1:0] lvl_pins,
    output logic               core_clk_en,
    output logic               in_backup,
    output logic               restart_req,
    output logic               sp_load,
    output logic [SP_W-1:0]    sp_load_val,
    output logic               pdn_flag,
    output logic               skip_req,
    output logic               ext_irq_req
);
    pwr_state_e state;
    logic       enter;
    logic       wake_evt;
    logic       wake_go;

    assign in_backup = (state == PS_BACKUP);

    bwc_entry_det i_entry (
        .clk          (clk),
        .rst_n        (rst_n),
        .armed        (~in_backup),
        .instr_valid  (instr_valid),
        .instr_is_pof (instr_is_pof),
        .enter        (enter)
    );

    bwc_wake_det #(
        .NUM_GRP_A (NUM_GRP_A),
        .NUM_GRP_B (NUM_GRP_B)
    ) i_wake_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_backup   (in_backup),
        .wake_ctl    (wake_ctl),
        .edge_pin    (edge_pin),
        .lvl_pins    (lvl_pins),
        .wake_evt    (wake_evt),
        .ext_irq_req (ext_irq_req)
    );

    bwc_wake_sync #(
        .SYNC_STAGES (SYNC_STAGES)
    ) i_wake_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_backup (in_backup),
        .wake_evt  (wake_evt),
        .wake_go   (wake_go)
    );

    // Power state: run -> backup on entry pair, backup -> run on synchronized wake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_RUN;
        end else if (enter) begin
            state <= PS_BACKUP;
        end else if (wake_go) begin
            state <= PS_RUN;
        end
    end

    // Core clock enable, held as its own register for a clean gate control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_clk_en <= 1'b1;
        end else if (enter) begin
            core_clk_en <= 1'b0;
        end else if (wake_go) begin
            core_clk_en <= 1'b1;
        end
    end

    // Restart strobe: held in reset, one pulse on leaving backup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            restart_req <= 1'b1;
        end else begin
            restart_req <= wake_go;
        end
    end

    // Stack-pointer load strobe on entry to backup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_load <= 1'b0;
        end else begin
            sp_load <= enter;
        end
    end

    // Sticky power-down flag: set on entry, cleared only by cold reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdn_flag <= 1'b0;
        end else if (enter) begin
            pdn_flag <= 1'b1;
        end
    end

    assign sp_load_val = SP_W'(SP_BACKUP);
    assign skip_req    = instr_valid & instr_is_test & pdn_flag & ~in_backup;

    AST_ENTRY_AFTER_POF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_backup) |-> $past(instr_valid && instr_is_pof)); // R1
    AST_CLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        in_backup |-> !core_clk_en); // R2
    AST_EXIT_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_backup) |-> (restart_req && core_clk_en)); // R7
    AST_SP_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_backup) |-> sp_load); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pdn_flag |=> pdn_flag); // R8
    AST_FLAG_IN_BACKUP: assert property (@(posedge clk) disable iff (!rst_n)
        in_backup |-> pdn_flag); // R8
endmodule

// File: tb/test_backup_wake_ctrl.sv
module test_backup_wake_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       instr_valid = 1'b0;
    logic       instr_is_pof = 1'b0;
    logic       instr_is_test = 1'b0;
    logic [2:0] wake_ctl = 3'b000;
    logic       edge_pin = 1'b1;
    logic [6:0] lvl_pins = 7'h7f;
    logic       core_clk_en, in_backup, restart_req, sp_load, pdn_flag, skip_req, ext_irq_req;
    logic [1:0] sp_load_val;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    backup_wake_ctrl i_backup_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_is_pof(instr_is_pof),
        .instr_is_test(instr_is_test), .wake_ctl(wake_ctl), .edge_pin(edge_pin),
        .lvl_pins(lvl_pins), .core_clk_en(core_clk_en), .in_backup(in_backup),
        .restart_req(restart_req), .sp_load(sp_load), .sp_load_val(sp_load_val),
        .pdn_flag(pdn_flag), .skip_req(skip_req), .ext_irq_req(ext_irq_req)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Cold reset, with reset-state checks (R2, R7, R8, R9).
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2", "clk_en in reset", core_clk_en, 1);
        chk("R7", "restart in reset", restart_req, 1);
        chk("R8", "flag in reset", pdn_flag, 0);
        chk("R9", "sp_load in reset", sp_load, 0);
        chk("R1", "backup in reset", in_backup, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R7", "restart after reset", restart_req, 0);
    endtask

    // Present one instruction for one clock edge.
    task automatic instr(input bit pof);
        instr_valid  = 1'b1;
        instr_is_pof = pof;
        @(negedge clk);
        instr_valid  = 1'b0;
        instr_is_pof = 1'b0;
    endtask

    task automatic enter_backup();
        instr(1'b1);
        chk("R1", "single pof no entry", in_backup, 0);
        instr(1'b1);
        chk("R1", "pof pair enters", in_backup, 1);
        chk("R2", "clk_en off in backup", core_clk_en, 0);
        chk("R9", "sp_load pulse", sp_load, 1);
        chk("R9", "sp_load value", sp_load_val, 3);
        chk("R8", "flag set on entry", pdn_flag, 1);
        @(negedge clk);
        chk("R9", "sp_load one cycle", sp_load, 0);
    endtask

    // One sweep case: src 0 correct edge, 1 reversed edge, 2..8 level pin src-2.
    task automatic wake_case(input bit pol, input bit [1:0] en, input int src);
        bit exp_wake;
        int pin;
        wake_ctl = {pol, en};
        lvl_pins = 7'h7f;
        edge_pin = (src == 1) ? pol : ~pol;
        do_reset();
        enter_backup();
        pin = src - 2;
        if (src == 0) exp_wake = 1'b1;
        else if (src == 1) exp_wake = 1'b0;
        else exp_wake = (pin < 3) ? en[0] : en[1];
        if (src <= 1) edge_pin = ~edge_pin;
        else lvl_pins[pin] = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7", "still in backup during sync", in_backup, 1);
            chk("R6", "no irq during backup", ext_irq_req, 0);
        end
        @(negedge clk);
        chk(src == 0 ? "R3" : (src == 1 ? "R3" : "R5"), "woke", !in_backup, exp_wake);
        chk("R2", "clk_en after wake window", core_clk_en, exp_wake);
        chk("R7", "restart pulse", restart_req, exp_wake);
        chk("R6", "no irq at exit", ext_irq_req, 0);
        if (exp_wake) begin
            if (src == 0) chk("R4", "edge wakes regardless of enables", in_backup, 0);
            @(negedge clk);
            chk("R7", "restart one cycle", restart_req, 0);
            chk("R6", "no irq after wake", ext_irq_req, 0);
            chk("R8", "flag kept after wake", pdn_flag, 1);
            instr_valid = 1'b1;
            instr_is_test = 1'b1;
            #1;
            chk("R8", "skip on warm start", skip_req, 1);
            @(negedge clk);
            instr_valid = 1'b0;
            instr_is_test = 1'b0;
        end
        lvl_pins = 7'h7f;
    endtask

    initial begin
        // Reset state and cold-start flag test.
        do_reset();
        instr_valid = 1'b1;
        instr_is_test = 1'b1;
        #1;
        chk("R8", "no skip on cold start", skip_req, 0);
        @(negedge clk);
        instr_valid = 1'b0;
        instr_is_test = 1'b0;

        // Entry ordering (R1).
        instr(1'b1);
        repeat (3) @(negedge clk);
        chk("R1", "single pof then bubbles", in_backup, 0);
        instr(1'b0);
        instr(1'b1);
        chk("R1", "pof split by other instr", in_backup, 0);
        @(negedge clk);
        instr(1'b1);
        chk("R1", "bubble does not break pair", in_backup, 1);
        do_reset();

        // Run-mode interrupt on both polarities (R6).
        for (int p = 0; p < 2; p++) begin
            wake_ctl = {p[0], 2'b00};
            edge_pin = ~p[0];
            repeat (2) @(negedge clk);
            edge_pin = p[0];
            @(negedge clk);
            chk("R6", "irq on selected edge", ext_irq_req, 1);
            @(negedge clk);
            chk("R6", "irq one cycle", ext_irq_req, 0);
            edge_pin = ~p[0];
            @(negedge clk);
            chk("R3", "no irq on reversed edge", ext_irq_req, 0);
        end

        // Sweep of polarity, group enables and sources (R3, R4, R5, R6, R7, R8).
        for (int p = 0; p < 2; p++)
            for (int e = 0; e < 4; e++)
                for (int s = 0; s < 9; s++)
                    wake_case(p[0], e[1:0], s);

        // Reset coincident with a wake event (R10).
        wake_ctl = 3'b100;
        edge_pin = 1'b0;
        lvl_pins = 7'h7f;
        do_reset();
        enter_backup();
        rst_n = 1'b0;
        edge_pin = 1'b1;
        @(negedge clk);
        chk("R10", "reset wins: running", in_backup, 0);
        chk("R10", "reset wins: flag", pdn_flag, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R10", "after reset: running", in_backup, 0);
        chk("R10", "after reset: clk_en", core_clk_en, 1);
        chk("R10", "after reset: flag", pdn_flag, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule